// File: doc/BRIEF.md
# Release-Flushing Posted Write Buffer

This block sits between a processor's store port and a shared system bus. Ordinary stores are posted into a small in-order queue and drained to the bus one write at a time. Each entry leaves the queue only when the bus acknowledges it. The processor therefore does not wait for bus writes unless the queue is full.

A lock release has its own request, separate from the store request. It carries the address and data of the release write. Once a release is accepted, the store port refuses new entries. The buffer first drains every write queued before the release, and only then puts the release write itself on the bus. When that write is acknowledged, a one-cycle done pulse tells the processor the release is globally visible, and the store port opens again. No write queued earlier can therefore become visible after the lock is seen as free. The release port accepts only one release at a time. Non-store activity of the processor is never stalled; backpressure appears only on the store port.

Top module: `wbuf_release`

## Requirements
- R1: While `rst` is high at a clock edge, the queue is emptied and any pending release is dropped. After that edge, `st_rdy` and `rel_rdy` are 1 and `bus_req` and `rel_done` are 0.
- R2: A store is taken at a rising edge where `st_req` and `st_rdy` are both 1. The queue holds up to DEPTH (default 8) stores. With DEPTH entries held, `st_rdy` is 0.
- R3: Stores reach the bus in the order they were taken. The bus carries the store's address on `bus_addr` and its data on `bus_data`. An entry is removed only at an edge where `bus_req` and `bus_ack` are both 1.
- R4: Once `bus_req` is 1 without `bus_ack`, the next cycle still has `bus_req` at 1, with the same `bus_addr` and `bus_data`. Only one write is outstanding.
- R5: From the edge that accepts a release (`rel_req` and `rel_rdy` both 1) until the cycle in which `rel_done` is 1, `st_rdy` is 0. A store taken at the same edge as the release counts as earlier than it.
- R6: The release write, carrying `rel_addr`/`rel_data` latched at acceptance, goes on the bus only after every earlier store has been acknowledged. It is the last write before `rel_done`.
- R7: `rel_done` is 1 for exactly one cycle: the cycle right after the edge at which the release write is acknowledged.
- R8: `rel_rdy` is 0 while a release is pending. A second release held on `rel_req` is taken only once the first has completed, and its write follows the first release write.
- R9: A reset in the middle of a drain discards the queued stores and the pending release. No bus write and no `rel_done` follow it.
- R10: A store presented while `st_rdy` is 0 is not taken. If it is held, it is taken once `st_rdy` returns, and it reaches the bus after the release write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_req | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_rdy | output | 1 | Store port can take an entry |
| rel_req | input | 1 | Lock-release request |
| rel_addr | input | ADDR_W | Release write address |
| rel_data | input | DATA_W | Release write data |
| rel_rdy | output | 1 | No release pending; a release can be taken |
| rel_done | output | 1 | One-cycle pulse: release write acknowledged |
| bus_req | output | 1 | Bus write request, held until acknowledged |
| bus_addr | output | ADDR_W | Bus write address |
| bus_data | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Bus write acknowledge |

## Verification
Some rules are checked by the assertions on every cycle:
- the bus request and its address and data are held until acknowledged;
- occupancy never exceeds the depth, and a full queue blocks stores;
- accepting a release closes the store port and the release port;
- the done pulse lasts one cycle and follows an acknowledge;
- the reset state.

Other properties only the bench's scenarios can show:
- the order of the writes on the bus, with stores strictly in FIFO order and the release write last;
- that a store blocked during a drain lands after the release write;
- that a second release waits for the first;
- that a reset in the middle of a drain leaves no trailing writes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        REL_IDLE  = 2'd0,
        REL_DRAIN = 2'd1,
        REL_ISSUE = 2'd2
    } rel_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] occ
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_d, s_q;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = push_data;
            s_d.wp          = ptr_next(s_q.wp);
        end
        if (pop) begin
            s_d.rp = ptr_next(s_q.rp);
        end
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign occ   = s_q.cnt;
endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq
    import wbuf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rel_req,
    input  logic [AW-1:0] rel_addr,
    input  logic [DW-1:0] rel_data,
    input  logic          q_empty,
    input  logic          q_full,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          bus_ack,
    output logic          st_rdy,
    output logic          rel_rdy,
    output logic          rel_done,
    output logic          q_pop,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data
);
    typedef struct packed {
        rel_state_e    st;
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;
    logic issuing_rel;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        issuing_rel = (s_q.st == REL_ISSUE);
        rel_rdy     = (s_q.st == REL_IDLE);
        st_rdy      = (s_q.st == REL_IDLE) && !q_full;
        bus_req     = issuing_rel || !q_empty;
        bus_addr    = issuing_rel ? s_q.ra : head_addr;
        bus_data    = issuing_rel ? s_q.rd : head_data;
        q_pop       = !issuing_rel && !q_empty && bus_ack;

        unique case (s_q.st)
            REL_IDLE: begin
                if (rel_req) begin
                    s_d.st = REL_DRAIN;
                    s_d.ra = rel_addr;
                    s_d.rd = rel_data;
                end
            end
            REL_DRAIN: begin
                if (q_empty) s_d.st = REL_ISSUE;
            end
            REL_ISSUE: begin
                if (bus_ack) begin
                    s_d.st   = REL_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = REL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{st: REL_IDLE, ra: '0, rd: '0, done: 1'b0};
        else     s_q <= s_d;
    end

    assign rel_done = s_q.done;
endmodule

// File: rtl/wbuf_release.sv
module wbuf_release #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int EW    = ADDR_W + DATA_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_rdy,
    input  logic              rel_req,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [DATA_W-1:0] rel_data,
    output logic              rel_rdy,
    output logic              rel_done,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ack
);
    logic          push, pop, q_empty, q_full;
    logic [EW-1:0] head;
    logic [CW-1:0] occ;

    assign push = st_req && st_rdy;

    wbuf_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data ({st_addr, st_data}),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full),
        .occ       (occ)
    );

    wbuf_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .rel_req   (rel_req),
        .rel_addr  (rel_addr),
        .rel_data  (rel_data),
        .q_empty   (q_empty),
        .q_full    (q_full),
        .head_addr (head[EW-1:DATA_W]),
        .head_data (head[DATA_W-1:0]),
        .bus_ack   (bus_ack),
        .st_rdy    (st_rdy),
        .rel_rdy   (rel_rdy),
        .rel_done  (rel_done),
        .q_pop     (pop),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data)
    );
endmodule

// File: rtl/wbuf_release_chk.sv
module wbuf_release_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              st_req,
    input logic              st_rdy,
    input logic              rel_req,
    input logic              rel_rdy,
    input logic              rel_done,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_ack,
    input logic [CW-1:0]     occ
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!bus_req && !rel_done && rel_rdy && st_rdy));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEPTH)) |-> !st_rdy);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_data)));

    assert_store_closed_R5: assert property (@(posedge clk) disable iff (rst)
        (rel_req && rel_rdy) |=> !st_rdy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rel_done |=> !rel_done);

    assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
        rel_done |-> $past(bus_req && bus_ack));

    assert_single_release_R8: assert property (@(posedge clk) disable iff (rst)
        (rel_req && rel_rdy) |=> !rel_rdy);
endmodule

bind wbuf_release wbuf_release_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .st_req   (st_req),
    .st_rdy   (st_rdy),
    .rel_req  (rel_req),
    .rel_rdy  (rel_rdy),
    .rel_done (rel_done),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_ack  (bus_ack),
    .occ      (occ)
);

// File: tb/sim_wbuf_release.sv
`timescale 1ns/1ps
module sim_wbuf_release;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_req = 1'b0, rel_req = 1'b0, bus_ack = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, rel_addr = '0, rel_data = '0;
    logic        st_rdy, rel_rdy, rel_done, bus_req;
    logic [31:0] bus_addr, bus_data;

    always #2.5 clk = ~clk;

    wbuf_release u0 (
        .clk(clk), .rst(rst),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_rdy(st_rdy),
        .rel_req(rel_req), .rel_addr(rel_addr), .rel_data(rel_data),
        .rel_rdy(rel_rdy), .rel_done(rel_done),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_ack(bus_ack)
    );

    int checks = 0, fails = 0;
    int lat = 0, wcnt = 0, cyc = 0, last_ack_cyc = 0, done_cnt = 0;
    logic [63:0] log_q [64];
    logic [63:0] exp_q [64];
    int log_n = 0, exp_n = 0;

    // {addr[15:0], data[15:0], bus latency[3:0]}
    localparam logic [35:0] VEC [10] = '{
        36'h0010_1111_0, 36'h0014_2222_2, 36'h0018_3333_0, 36'h001C_4444_5,
        36'h0100_5555_1, 36'h0104_6666_0, 36'h0F00_7777_3, 36'hFFFC_8888_0,
        36'h0200_9999_4, 36'h0204_AAAA_1
    };

    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
    end

    // bus responder
    initial forever begin
        @(negedge clk);
        if (rst) begin
            bus_ack = 1'b0; wcnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                bus_ack = 1'b1; wcnt = 0;
                last_ack_cyc = cyc;
                if (log_n < 64) log_q[log_n] = {bus_addr, bus_data};
                log_n = log_n + 1;
            end else wcnt = wcnt + 1;
        end
    end

    initial forever begin
        @(negedge clk);
        if (rel_done) done_cnt = done_cnt + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks = checks + 1;
        if (act !== expv) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        st_req = 1'b1; st_addr = a; st_data = d;
        while (!st_rdy) @(negedge clk);
        exp_q[exp_n] = {a, d}; exp_n = exp_n + 1;
        @(negedge clk);
        st_req = 1'b0;
    endtask

    task automatic do_release(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        rel_req = 1'b1; rel_addr = a; rel_data = d;
        while (!rel_rdy) @(negedge clk);
        exp_q[exp_n] = {a, d}; exp_n = exp_n + 1;
        @(negedge clk);
        rel_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!bus_req && !bus_ack && rel_rdy) break;
        end
    endtask

    task automatic wait_done(input string req);
        int i;
        for (i = 0; i < 3000; i++) begin
            if (rel_done) break;
            @(negedge clk);
        end
        check(req, 64'(rel_done), 64'd1);
    endtask

    task automatic clear_log();
        log_n = 0; exp_n = 0;
    endtask

    task automatic check_log(input string req);
        check(req, 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < 64; i++) check(req, log_q[i], exp_q[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1; fails = fails + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int bad, dc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 st_rdy", 64'(st_rdy), 64'd1);
        check("R1 rel_rdy", 64'(rel_rdy), 64'd1);
        check("R1 bus_req", 64'(bus_req), 64'd0);
        check("R1 rel_done", 64'(rel_done), 64'd0);

        // R3: table-driven stores with varied bus latency, drained in order
        clear_log();
        for (int v = 0; v < 10; v++) begin
            lat = int'(VEC[v][3:0]);
            push_store({16'hA5A5, VEC[v][35:20]}, {16'h0, VEC[v][19:4]});
        end
        wait_idle();
        check_log("R3 order");

        // R2: fill with a stalled bus; a ninth store must not be taken (R10)
        clear_log();
        lat = 100000;
        for (int k = 0; k < 8; k++) push_store(32'h1000 + 32'(k * 4), 32'hC0 + 32'(k));
        check("R2 full st_rdy", 64'(st_rdy), 64'd0);
        @(negedge clk);
        st_req = 1'b1; st_addr = 32'hDEAD; st_data = 32'hDEAD;
        repeat (4) @(negedge clk);
        check("R10 full no take", 64'(st_rdy), 64'd0);
        st_req = 1'b0;
        lat = 0;
        wait_idle();
        check_log("R2 drain");

        // R5/R6/R7/R10: release behind three stores, a store held during drain
        clear_log();
        lat = 3;
        push_store(32'h2000, 32'h11);
        push_store(32'h2004, 32'h22);
        push_store(32'h2008, 32'h33);
        do_release(32'h3000, 32'h1);
        check("R5 st_rdy after accept", 64'(st_rdy), 64'd0);
        check("R8 rel_rdy after accept", 64'(rel_rdy), 64'd0);
        st_req = 1'b1; st_addr = 32'h2100; st_data = 32'h44;
        bad = 0;
        for (int i = 0; i < 3000 && !rel_done; i++) begin
            if (st_rdy) bad = bad + 1;
            @(negedge clk);
        end
        check("R5 closed during drain", 64'(bad), 64'd0);
        check("R7 done seen", 64'(rel_done), 64'd1);
        check("R7 done one cycle after ack", 64'(cyc), 64'(last_ack_cyc + 1));
        check("R10 open at done", 64'(st_rdy), 64'd1);
        exp_q[exp_n] = {32'h2100, 32'h44}; exp_n = exp_n + 1;
        @(negedge clk);
        st_req = 1'b0;
        check("R7 pulse width", 64'(rel_done), 64'd0);
        wait_idle();
        check_log("R6 release after stores");

        // R6: release on an empty buffer
        clear_log();
        lat = 1;
        do_release(32'h3100, 32'h0);
        wait_done("R6 empty release done");
        wait_idle();
        check_log("R6 empty release only write");

        // R8: second release held until first completes
        clear_log();
        lat = 6;
        push_store(32'h4000, 32'h5);
        push_store(32'h4004, 32'h6);
        do_release(32'h4100, 32'hA);
        rel_req = 1'b1; rel_addr = 32'h4200; rel_data = 32'hB;
        bad = 0;
        for (int i = 0; i < 3000 && !rel_done; i++) begin
            if (rel_rdy) bad = bad + 1;
            @(negedge clk);
        end
        check("R8 second held", 64'(bad), 64'd0);
        check("R8 open at done", 64'(rel_rdy), 64'd1);
        exp_q[exp_n] = {32'h4200, 32'hB}; exp_n = exp_n + 1;
        @(negedge clk);
        rel_req = 1'b0;
        check("R8 second taken", 64'(rel_rdy), 64'd0);
        wait_done("R8 second done");
        wait_idle();
        check_log("R8 order");

        // R9: reset during a stalled drain
        clear_log();
        lat = 100000;
        for (int k = 0; k < 4; k++) push_store(32'h5000 + 32'(k * 4), 32'(k));
        do_release(32'h5100, 32'h1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 bus_req", 64'(bus_req), 64'd0);
        check("R9 st_rdy", 64'(st_rdy), 64'd1);
        check("R9 rel_rdy", 64'(rel_rdy), 64'd1);
        lat = 0; log_n = 0; dc = done_cnt;
        repeat (20) @(negedge clk);
        check("R9 no writes", 64'(log_n), 64'd0);
        check("R9 no done", 64'(done_cnt), 64'(dc));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule